// File: doc/BRIEF.md
# UART register and interrupt front end

This block is the register file a processor sees when it talks to a memory-mapped UART. It takes single-cycle accesses on a simple 32-bit bus with a 4 KB window. It keeps the baud divisor, line, control and level settings. It serves a read-only identification table in the top 32 bytes of the window. It gathers the transmit and receive interrupt sources into a raw register, masks them, and drives one level-sensitive interrupt line.

On the receive side it is wired to an external queue. The queue supplies its head entry, fill count, empty flag and full flag, and the block answers with a one-cycle pop strobe. On the transmit side a write to the data register produces a one-cycle byte strobe. Serial shifting and baud timing are handled elsewhere.

Read data is registered. It appears on `bus_rdata` in the cycle after the access clock edge and holds until the next read. Write effects are also visible after that edge.

Top module: `uart_regfront`

## Requirements
- R1: After reset, `bus_rdata`, `irq`, `bus_err`, `tx_valid` and `rxq_pop` are 0. The mask and raw registers read as 0.
- R2: The writable settings read back with the following widths, with unused bits read as 0. Offset 0x20 keeps 8 bits, 0x24 keeps 16 bits, 0x28 keeps 6 bits, 0x2C keeps 8 bits, 0x30 keeps 16 bits, 0x34 keeps 6 bits and 0x38 (mask) keeps 11 bits.
- R3: A read at 0xFE0 + 4k (k = 0..7) returns byte k of the table 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1. A write anywhere in 0xFE0..0xFFF is an error under R11.
- R4: A write to offset 0x00 makes `tx_valid` high for exactly the next cycle, with `tx_data` equal to the low byte written. It also sets raw bit 5, the transmit source.
- R5: The masked register at 0x40 reads raw AND mask. `irq` is high exactly when that value is nonzero. The raw register is at 0x3C, bit 5 is transmit and bit 4 is receive.
- R6: A write to 0x44 clears each raw bit written as 1 and leaves the other raw bits unchanged.
- R7: A read of 0x18 returns bit 7 = 1 (transmitter empty), bit 6 = `rxq_full`, bit 5 = 0 and bit 4 = `rxq_empty`, with all other bits 0. Writes to 0x18, 0x3C and 0x40 change nothing.
- R8: A read of 0x00 returns the `rxq_data` value present at the access edge, zero-extended. `rxq_pop` is high during that access only when `rxq_empty` is 0.
- R9: Raw bit 4 sets when `rxq_count` rises from below the receive threshold to at or above it. It clears when the count is below the threshold or when it is cleared under R6.
- R10: The threshold is 1 when bit 4 of 0x2C is 0. When that bit is 1, the threshold is 4 × bits [5:3] of 0x34, or 1 if that field is 0. A new threshold is recomputed from writes to 0x2C or 0x34 and applies from the next cycle.
- R11: `bus_err` goes high and stays high until reset on any of these accesses: a nonzero write to 0x48, a write to the ID range, an access with nonzero address bits [1:0], or an access to an offset not listed here. Reads of 0x44, 0x48 and undecoded offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| rxq_data | input | 12 | Head entry of the receive queue |
| rxq_count | input | 5 | Receive queue fill count |
| rxq_empty | input | 1 | Receive queue empty |
| rxq_full | input | 1 | Receive queue full |
| rxq_pop | output | 1 | Pop strobe to the receive queue |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |
| bus_err | output | 1 | Sticky access error |

## Verification
The register file is first walked with all-ones writes, which show that each setting keeps exactly its own width. Readback of mid-range patterns then tells the registers apart from one another, and the eight ID reads separate the table order from the index arithmetic.

Interrupt behaviour is tried in three ways:
- a transmit write observed under a closed mask and then an open mask;
- selective clears;
- receive counts stepped just below and just onto the threshold, with the FIFO both off and on and with the zero-field floor.

Data reads are made with the queue holding an entry and with it empty, which separates the pop guard from the returned value. Each error source is tried on a fresh reset so that the sticky flag cannot hide which access raised it.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_FLAG, SEL_ILPR, SEL_IBRD, SEL_FBRD, SEL_LCR,
    SEL_CR, SEL_IFLS, SEL_IMSC, SEL_RIS, SEL_MIS, SEL_ICR, SEL_DMA, SEL_ID
  } sel_e;

  localparam int BIT_TX = 5;
  localparam int BIT_RX = 4;

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: id_byte = 8'h11;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode import uart_rf_pkg::*; #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [2:0]        id_k
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  assign widx = addr[ADDR_W-1:2];
  assign id_k = addr[4:2];

  always_comb begin
    sel = SEL_NONE;
    if (addr[1:0] != 2'b00) begin
      sel = SEL_NONE;
    end else if (&addr[ADDR_W-1:5]) begin
      sel = SEL_ID;
    end else begin
      case (widx)
        WIDX_W'(0):  sel = SEL_DATA;
        WIDX_W'(6):  sel = SEL_FLAG;
        WIDX_W'(8):  sel = SEL_ILPR;
        WIDX_W'(9):  sel = SEL_IBRD;
        WIDX_W'(10): sel = SEL_FBRD;
        WIDX_W'(11): sel = SEL_LCR;
        WIDX_W'(12): sel = SEL_CR;
        WIDX_W'(13): sel = SEL_IFLS;
        WIDX_W'(14): sel = SEL_IMSC;
        WIDX_W'(15): sel = SEL_RIS;
        WIDX_W'(16): sel = SEL_MIS;
        WIDX_W'(17): sel = SEL_ICR;
        WIDX_W'(18): sel = SEL_DMA;
        default:     sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq import uart_rf_pkg::*; #(
  parameter int IRQ_W  = 11,
  parameter int CNT_W  = 5,
  parameter int TRIG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_set,
  input  logic              clr_we,
  input  logic              mask_we,
  input  logic [IRQ_W-1:0]  wval,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [TRIG_W-1:0] trig,
  output logic [IRQ_W-1:0]  ris,
  output logic [IRQ_W-1:0]  imsc,
  output logic [IRQ_W-1:0]  mis,
  output logic              irq
);
  logic [IRQ_W-1:0] ris_q, ris_d, imsc_q, imsc_d;
  logic [CNT_W-1:0] cnt_prev_q;
  logic             above, was_above;

  assign above     = TRIG_W'(rx_count)   >= trig;
  assign was_above = TRIG_W'(cnt_prev_q) >= trig;

  always_comb begin
    ris_d  = ris_q & ~(clr_we ? wval : '0);
    imsc_d = mask_we ? wval : imsc_q;
    if (tx_set) ris_d[BIT_TX] = 1'b1;
    ris_d[BIT_RX] = (above & ~was_above) | (ris_d[BIT_RX] & above);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ris_q      <= '0;
      imsc_q     <= '0;
      cnt_prev_q <= '0;
    end else begin
      ris_q      <= ris_d;
      imsc_q     <= imsc_d;
      cnt_prev_q <= rx_count;
    end
  end

  assign ris  = ris_q;
  assign imsc = imsc_q;
  assign mis  = ris_q & imsc_q;
  assign irq  = |mis;
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront import uart_rf_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int RXD_W  = 12,
  parameter int CNT_W  = 5,
  parameter int IRQ_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [RXD_W-1:0]  rxq_data,
  input  logic [CNT_W-1:0]  rxq_count,
  input  logic              rxq_empty,
  input  logic              rxq_full,
  output logic              rxq_pop,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq,
  output logic              bus_err
);
  localparam int TRIG_W = CNT_W + 2;

  sel_e       sel;
  logic [2:0] id_k;
  logic       acc_wr, acc_rd;

  uart_rf_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel), .id_k(id_k));

  assign acc_wr = bus_sel & bus_wr;
  assign acc_rd = bus_sel & ~bus_wr;

  logic [7:0]  ilpr_q, ilpr_d, lcr_q, lcr_d;
  logic [15:0] ibrd_q, ibrd_d, cr_q, cr_d;
  logic [5:0]  fbrd_q, fbrd_d, ifls_q, ifls_d;
  logic [TRIG_W-1:0] trig_q, trig_d;
  logic        trig_en;

  always_comb begin
    ilpr_d = ilpr_q; ibrd_d = ibrd_q; fbrd_d = fbrd_q;
    lcr_d  = lcr_q;  cr_d   = cr_q;   ifls_d = ifls_q;
    if (acc_wr) begin
      case (sel)
        SEL_ILPR: ilpr_d = bus_wdata[7:0];
        SEL_IBRD: ibrd_d = bus_wdata[15:0];
        SEL_FBRD: fbrd_d = bus_wdata[5:0];
        SEL_LCR:  lcr_d  = bus_wdata[7:0];
        SEL_CR:   cr_d   = bus_wdata[15:0];
        SEL_IFLS: ifls_d = bus_wdata[5:0];
        default: ;
      endcase
    end
  end

  assign trig_en = acc_wr & ((sel == SEL_LCR) | (sel == SEL_IFLS));

  always_comb begin
    if (!lcr_d[4] || ifls_d[5:3] == 3'd0) trig_d = TRIG_W'(1);
    else                                   trig_d = TRIG_W'({ifls_d[5:3], 2'b00});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ilpr_q <= '0; ibrd_q <= '0; fbrd_q <= '0;
      lcr_q  <= '0; cr_q   <= '0; ifls_q <= '0;
      trig_q <= TRIG_W'(1);
    end else begin
      ilpr_q <= ilpr_d; ibrd_q <= ibrd_d; fbrd_q <= fbrd_d;
      lcr_q  <= lcr_d;  cr_q   <= cr_d;   ifls_q <= ifls_d;
      if (trig_en) trig_q <= trig_d;
    end
  end

  logic [IRQ_W-1:0] ris, imsc, mis;
  logic             tx_set;

  assign tx_set = acc_wr & (sel == SEL_DATA);

  uart_rf_irq #(.IRQ_W(IRQ_W), .CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .tx_set(tx_set),
    .clr_we(acc_wr & (sel == SEL_ICR)), .mask_we(acc_wr & (sel == SEL_IMSC)),
    .wval(bus_wdata[IRQ_W-1:0]), .rx_count(rxq_count), .trig(trig_q),
    .ris(ris), .imsc(imsc), .mis(mis), .irq(irq)
  );

  assign rxq_pop = acc_rd & (sel == SEL_DATA) & ~rxq_empty;

  logic [7:0]        flags;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign flags = {1'b1, rxq_full, 1'b0, rxq_empty, 4'b0000};

  always_comb begin
    case (sel)
      SEL_DATA: rd_mux = DATA_W'(rxq_data);
      SEL_FLAG: rd_mux = DATA_W'(flags);
      SEL_ILPR: rd_mux = DATA_W'(ilpr_q);
      SEL_IBRD: rd_mux = DATA_W'(ibrd_q);
      SEL_FBRD: rd_mux = DATA_W'(fbrd_q);
      SEL_LCR:  rd_mux = DATA_W'(lcr_q);
      SEL_CR:   rd_mux = DATA_W'(cr_q);
      SEL_IFLS: rd_mux = DATA_W'(ifls_q);
      SEL_IMSC: rd_mux = DATA_W'(imsc);
      SEL_RIS:  rd_mux = DATA_W'(ris);
      SEL_MIS:  rd_mux = DATA_W'(mis);
      SEL_ID:   rd_mux = DATA_W'(id_byte(id_k));
      default:  rd_mux = '0;
    endcase
  end

  logic err_q, err_set, tx_valid_q;
  logic [7:0] tx_data_q;

  assign err_set = bus_sel & ((sel == SEL_NONE) |
                              (bus_wr & (sel == SEL_ID)) |
                              (bus_wr & (sel == SEL_DMA) & (|bus_wdata)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q    <= '0;
      err_q      <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      if (acc_rd)  rdata_q   <= rd_mux;
      if (err_set) err_q     <= 1'b1;
      tx_valid_q <= tx_set;
      if (tx_set)  tx_data_q <= bus_wdata[7:0];
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign tx_valid  = tx_valid_q;
  assign tx_data   = tx_data_q;
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rxq_empty,
  input logic              rxq_pop,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              irq,
  input logic              bus_err
);
  logic data_wr, mask_zero_wr, id_wr;

  assign data_wr      = bus_sel & bus_wr & (bus_addr == ADDR_W'(0));
  assign mask_zero_wr = bus_sel & bus_wr & (bus_addr == ADDR_W'(56)) &
                        (bus_wdata[IRQ_W-1:0] == '0);
  assign id_wr        = bus_sel & bus_wr & (&bus_addr[ADDR_W-1:5]);

  a_r4_tx_byte: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));

  a_r4_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> !tx_valid);

  a_r5_mask_closed: assert property (@(posedge clk) disable iff (!rst_n)
    mask_zero_wr |=> !irq);

  a_r8_pop_guard: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_pop |-> (!rxq_empty && bus_sel && !bus_wr));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> bus_err);

  a_r3_id_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    id_wr |=> bus_err);
endmodule

bind uart_regfront uart_regfront_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rxq_empty(rxq_empty),
  .rxq_pop(rxq_pop), .tx_valid(tx_valid), .tx_data(tx_data),
  .irq(irq), .bus_err(bus_err)
);

// File: tb/uart_regfront_tb_top.sv
`timescale 1ns/1ps
module uart_regfront_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [11:0] rxq_data;
  logic [4:0]  rxq_count;
  logic        rxq_empty, rxq_full, rxq_pop, tx_valid, irq, bus_err;
  logic [7:0]  tx_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxq_data(rxq_data), .rxq_count(rxq_count), .rxq_empty(rxq_empty),
    .rxq_full(rxq_full), .rxq_pop(rxq_pop), .tx_valid(tx_valid),
    .tx_data(tx_data), .irq(irq), .bus_err(bus_err)
  );

  // {write, addr, wdata, expected read}
  localparam int NV = 20;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 12'h024, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 12'h024, 32'h0, 32'h0000_FFFF},
    {1'b1, 12'h028, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 12'h028, 32'h0, 32'h0000_003F},
    {1'b1, 12'h020, 32'h0000_01FF, 32'h0},
    {1'b0, 12'h020, 32'h0, 32'h0000_00FF},
    {1'b1, 12'h030, 32'hABCD_1234, 32'h0},
    {1'b0, 12'h030, 32'h0, 32'h0000_1234},
    {1'b1, 12'h02C, 32'h0000_015A, 32'h0},
    {1'b0, 12'h02C, 32'h0, 32'h0000_005A},
    {1'b1, 12'h034, 32'h0000_00FF, 32'h0},
    {1'b0, 12'h034, 32'h0, 32'h0000_003F},
    {1'b0, 12'hFE0, 32'h0, 32'h11},
    {1'b0, 12'hFE4, 32'h0, 32'h10},
    {1'b0, 12'hFE8, 32'h0, 32'h14},
    {1'b0, 12'hFEC, 32'h0, 32'h00},
    {1'b0, 12'hFF0, 32'h0, 32'h0D},
    {1'b0, 12'hFF4, 32'h0, 32'hF0},
    {1'b0, 12'hFF8, 32'h0, 32'h05},
    {1'b0, 12'hFFC, 32'h0, 32'hB1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rxq_data = '0; rxq_count = '0; rxq_empty = 1'b1; rxq_full = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic pop);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 pop = rxq_pop;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        pp;
    rst_n = 1'b0;
    do_reset();

    // R1 reset state
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 err", {31'h0, bus_err}, 32'h0);
    chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    chk("R1 pop", {31'h0, rxq_pop}, 32'h0);
    bus_read(12'h038, rd, pp); chk("R1 mask", rd, 32'h0);
    bus_read(12'h03C, rd, pp); chk("R1 raw", rd, 32'h0);

    // R2 / R3 vector walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) bus_write(VEC[i][75:64], VEC[i][63:32]);
      else begin
        bus_read(VEC[i][75:64], rd, pp);
        chk(VEC[i][75:64] >= 12'hFE0 ? "R3 id" : "R2 readback", rd, VEC[i][31:0]);
      end
    end
    bus_write(12'h038, 32'hFFFF_FFFF);
    bus_read(12'h038, rd, pp); chk("R2 mask width", rd, 32'h7FF);
    bus_write(12'h038, 32'h0);
    chk("R3 no error from id reads", {31'h0, bus_err}, 32'h0);

    // R4 transmit
    do_reset();
    bus_write(12'h000, 32'h0000_01A5);
    chk("R4 tx_valid", {31'h0, tx_valid}, 32'h1);
    chk("R4 tx_data", {24'h0, tx_data}, 32'hA5);
    @(negedge clk);
    chk("R4 tx_valid one cycle", {31'h0, tx_valid}, 32'h0);
    bus_read(12'h03C, rd, pp); chk("R4 raw tx", rd, 32'h20);

    // R5 masked status and line
    bus_read(12'h040, rd, pp); chk("R5 masked closed", rd, 32'h0);
    chk("R5 irq closed", {31'h0, irq}, 32'h0);
    bus_write(12'h038, 32'h20);
    chk("R5 irq open", {31'h0, irq}, 32'h1);
    bus_read(12'h040, rd, pp); chk("R5 masked open", rd, 32'h20);

    // R7 writes to read-only status are ignored
    bus_write(12'h03C, 32'h0);
    bus_write(12'h040, 32'h0);
    bus_read(12'h03C, rd, pp); chk("R7 raw unchanged", rd, 32'h20);
    bus_write(12'h018, 32'h0);
    bus_read(12'h018, rd, pp); chk("R7 flags empty", rd, 32'h90);
    rxq_empty = 1'b0; rxq_full = 1'b1;
    bus_read(12'h018, rd, pp); chk("R7 flags full", rd, 32'hC0);

    // R6 selective clear
    bus_write(12'h044, 32'h10);
    bus_read(12'h03C, rd, pp); chk("R6 other bit kept", rd, 32'h20);
    bus_write(12'h044, 32'h20);
    bus_read(12'h03C, rd, pp); chk("R6 tx cleared", rd, 32'h0);
    chk("R6 irq low", {31'h0, irq}, 32'h0);

    // R8 data read with and without an entry
    rxq_full = 1'b0; rxq_data = 12'h3C5;
    bus_read(12'h000, rd, pp);
    chk("R8 data", rd, 32'h3C5);
    chk("R8 pop", {31'h0, pp}, 32'h1);
    rxq_empty = 1'b1; rxq_data = 12'h0AA;
    bus_read(12'h000, rd, pp);
    chk("R8 empty no pop", {31'h0, pp}, 32'h0);
    chk("R8 empty data", rd, 32'h0AA);

    // R9 / R10 receive threshold
    bus_write(12'h038, 32'h10);
    @(negedge clk); rxq_count = 5'd1; @(negedge clk);
    bus_read(12'h03C, rd, pp); chk("R9 rise fifo off", rd, 32'h10);
    chk("R9 irq", {31'h0, irq}, 32'h1);
    rxq_count = 5'd0; @(negedge clk);
    bus_read(12'h03C, rd, pp); chk("R9 drop clears", rd, 32'h0);
    bus_write(12'h02C, 32'h10);
    bus_write(12'h034, 32'h10);
    rxq_count = 5'd7; @(negedge clk);
    bus_read(12'h03C, rd, pp); chk("R10 below 8", rd, 32'h0);
    rxq_count = 5'd8; @(negedge clk);
    bus_read(12'h03C, rd, pp); chk("R10 at 8", rd, 32'h10);
    bus_write(12'h044, 32'h10);
    bus_read(12'h03C, rd, pp); chk("R9 clear while above", rd, 32'h0);
    rxq_count = 5'd0; @(negedge clk);
    bus_write(12'h034, 32'h00);
    rxq_count = 5'd1; @(negedge clk);
    bus_read(12'h03C, rd, pp); chk("R10 zero field floor", rd, 32'h10);

    // R11 error sources
    do_reset();
    bus_write(12'h048, 32'h0);
    chk("R11 dma zero ok", {31'h0, bus_err}, 32'h0);
    bus_read(12'h048, rd, pp); chk("R11 dma read", rd, 32'h0);
    bus_read(12'h044, rd, pp); chk("R11 clear read", rd, 32'h0);
    chk("R11 clear read no err", {31'h0, bus_err}, 32'h0);
    bus_write(12'h048, 32'h1);
    chk("R11 dma nonzero", {31'h0, bus_err}, 32'h1);
    do_reset();
    bus_read(12'h004, rd, pp);
    chk("R11 undecoded read", rd, 32'h0);
    chk("R11 undecoded err", {31'h0, bus_err}, 32'h1);
    @(negedge clk);
    chk("R11 sticky", {31'h0, bus_err}, 32'h1);
    do_reset();
    bus_read(12'h022, rd, pp);
    chk("R11 misaligned err", {31'h0, bus_err}, 32'h1);
    do_reset();
    bus_write(12'hFE0, 32'h1);
    chk("R3 id write err", {31'h0, bus_err}, 32'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule